// File: doc/BRIEF.md
# Stack Pointer Unit with Write Lockout

This block holds a processor's stack pointer and updates it for every kind of stack traffic. The stack grows toward lower addresses. A single-byte push stores at the current pointer and then moves the pointer down by one. A single-byte pop moves the pointer up by one and reads at the new value. Call and interrupt entry push a return address of `RET_BYTES` bytes, which is 2 for program stores up to 128 KB and 3 for larger ones. Return and return-from-interrupt pop it again. The block produces one memory address lane per return-address byte, so the memory side can perform a multi-byte access in a single cycle.

Software can read and write the pointer as a low byte and a high byte. A write to the low byte raises an interrupt-inhibit flag. The flag stays up until a set number of instructions have retired, or until the next I/O write, whichever comes first. This lets software write the high byte without an interrupt arriving in between. A software write that leaves the pointer at or below a protected floor address produces a one-cycle warning pulse.

Top module: `stack_ptr_unit`

## Requirements
- R1: While reset is held and in the first cycle after it, the pointer equals `SRAM_TOP`. In the same cycles `irq_block_o` and `bad_wr_o` are 0 and no lane is enabled.
- R2: Push:
  - In the request cycle, lane 0 is enabled with address = pointer and `acc_wr_o` = 1.
  - On the next cycle the pointer is one lower.
- R3: Pop:
  - In the request cycle, lane 0 is enabled with address = pointer + 1 and `acc_wr_o` = 0.
  - On the next cycle the pointer is one higher.
- R4: Call or interrupt entry:
  - In the request cycle all `RET_BYTES` lanes are enabled and `acc_wr_o` = 1. Lane b carries byte b of the return address (lane 0 is the least significant byte) at address pointer − b.
  - On the next cycle the pointer is `RET_BYTES` lower.
- R5: Return:
  - In the request cycle all lanes are enabled and `acc_wr_o` = 0. Lane b reads at pointer + `RET_BYTES` − b.
  - On the next cycle the pointer is `RET_BYTES` higher.
- R6: Software writes:
  - A write to the low or high byte (`wr_lo_i`, `wr_hi_i`) replaces that byte of the pointer on the next cycle, and both bytes may be written together.
  - A stack request in the same cycle is ignored: no lane is enabled and the pointer takes the written value.
- R7: Interrupt inhibit after a low-byte write:
  - `irq_block_o` is 1 from the cycle after the write.
  - It drops once `LOCK_INSNS` `retire_i` pulses have been seen in later cycles.
  - A retire pulse in the same cycle as the write is not counted.
- R8: While `irq_block_o` is 1, an `io_wr_i` or `wr_hi_i` pulse in a cycle without `wr_lo_i` clears it on the next cycle.
- R9: `bad_wr_o` is 1 for exactly the cycle after a software write whose resulting pointer is ≤ `FLOOR_ADDR`, and is 0 otherwise.
- R10: Idle cycles and request rules:
  - In a cycle with no request and no software write, the pointer holds and no lane is enabled.
  - At most one of push, pop, call and return may be requested per cycle.
  - Pointer arithmetic wraps modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Single-byte push request |
| pop_i | input | 1 | Single-byte pop request |
| call_i | input | 1 | Call or interrupt entry, pushes the return address |
| ret_i | input | 1 | Return or return-from-interrupt, pops the return address |
| retire_i | input | 1 | One instruction retired |
| io_wr_i | input | 1 | Some I/O location was written |
| wr_lo_i | input | 1 | Software write to the pointer low byte |
| wr_hi_i | input | 1 | Software write to the pointer high byte |
| wr_data_i | input | 8 | Byte written by software |
| sp_o | output | 16 | Current stack pointer |
| acc_addr_o | output | 16*RET_BYTES | Per-lane memory address, lane b in bits [16b+15:16b] |
| acc_en_o | output | RET_BYTES | Per-lane access enable |
| acc_wr_o | output | 1 | 1 = stack write, 0 = stack read |
| irq_block_o | output | 1 | Interrupts must not be taken |
| bad_wr_o | output | 1 | Last software write put the pointer at or below the floor |

## Verification
The assertions assume that the decoder never raises more than one of push, pop, call and return in the same cycle. This is the only input restriction, and a dedicated assertion checks it. The random stimulus draws a single request code per cycle, so the four request strobes are mutually exclusive by construction. Retire and I/O strobes and software writes are drawn independently of the request code and can coincide with it, which exercises the write-over-request priority and the lockout counting. Directed sequences cover the lockout expiring, the lockout being cut short by an I/O write, writes exactly at and one above the floor, and pointer wrap.

// File: rtl/sp_unit_pkg.sv
// Shared definitions for the stack pointer unit.
// Assumes a 16-bit data address space split into two bytes.
package sp_unit_pkg;
    localparam int SP_W = 16;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_PUSH,
        OP_POP,
        OP_CALL,
        OP_RET
    } stk_op_e;
endpackage

// File: rtl/sp_op_decode.sv
// Chooses the stack operation for this cycle, the pointer value it leads to,
// and the memory address of each byte lane.
// Assumes at most one request strobe is high; a software write suppresses all.
module sp_op_decode
    import sp_unit_pkg::*;
#(
    parameter int RET_BYTES = 2
) (
    input  logic                   push_i,
    input  logic                   pop_i,
    input  logic                   call_i,
    input  logic                   ret_i,
    input  logic                   sw_wr_i,
    input  logic [SP_W-1:0]        sp_i,
    output logic [SP_W-1:0]        sp_next_o,
    output logic [SP_W*RET_BYTES-1:0] addr_o,
    output logic [RET_BYTES-1:0]   en_o,
    output logic                   wr_o
);
    localparam logic [SP_W-1:0] STEP_RA = SP_W'(RET_BYTES);

    stk_op_e op;

    // Pick one operation; software writes take priority over all requests.
    always_comb begin
        if (sw_wr_i)     op = OP_NONE;
        else if (call_i) op = OP_CALL;
        else if (ret_i)  op = OP_RET;
        else if (push_i) op = OP_PUSH;
        else if (pop_i)  op = OP_POP;
        else             op = OP_NONE;
    end

    // Pointer value after the selected operation.
    always_comb begin
        unique case (op)
            OP_PUSH: sp_next_o = sp_i - 1'b1;
            OP_POP:  sp_next_o = sp_i + 1'b1;
            OP_CALL: sp_next_o = sp_i - STEP_RA;
            OP_RET:  sp_next_o = sp_i + STEP_RA;
            default: sp_next_o = sp_i;
        endcase
    end

    // Direction of the memory access.
    always_comb wr_o = (op == OP_PUSH) || (op == OP_CALL);

    for (genvar b = 0; b < RET_BYTES; b++) begin : g_lane
        localparam logic [SP_W-1:0] OFS_DN = SP_W'(b);
        localparam logic [SP_W-1:0] OFS_UP = SP_W'(RET_BYTES - b);
        // Address and enable of byte lane b.
        always_comb begin
            addr_o[b*SP_W +: SP_W] = '0;
            en_o[b]                = 1'b0;
            unique case (op)
                OP_PUSH: if (b == 0) begin
                    addr_o[b*SP_W +: SP_W] = sp_i;
                    en_o[b]                = 1'b1;
                end
                OP_POP: if (b == 0) begin
                    addr_o[b*SP_W +: SP_W] = sp_i + 1'b1;
                    en_o[b]                = 1'b1;
                end
                OP_CALL: begin
                    addr_o[b*SP_W +: SP_W] = sp_i - OFS_DN;
                    en_o[b]                = 1'b1;
                end
                OP_RET: begin
                    addr_o[b*SP_W +: SP_W] = sp_i + OFS_UP;
                    en_o[b]                = 1'b1;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/sp_reg.sv
// Pointer register with byte-wide software writes and a floor warning.
// Assumes the decoder already returns the unchanged pointer during a write.
module sp_reg
    import sp_unit_pkg::*;
#(
    parameter logic [SP_W-1:0] SRAM_TOP   = 16'h3FFF,
    parameter logic [SP_W-1:0] FLOOR_ADDR = 16'h2000
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_lo_i,
    input  logic            wr_hi_i,
    input  logic [7:0]      wr_data_i,
    input  logic [SP_W-1:0] op_next_i,
    output logic [SP_W-1:0] sp_o,
    output logic            bad_wr_o
);
    logic [SP_W-1:0] sw_val;
    logic [SP_W-1:0] nxt;
    logic            sw_wr;

    // Merge written bytes with the bytes left alone.
    always_comb begin
        sw_wr  = wr_lo_i | wr_hi_i;
        sw_val = {wr_hi_i ? wr_data_i : sp_o[15:8],
                  wr_lo_i ? wr_data_i : sp_o[7:0]};
        nxt    = sw_wr ? sw_val : op_next_i;
    end

    // Hold the pointer and the one-cycle floor warning.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp_o     <= SRAM_TOP;
            bad_wr_o <= 1'b0;
        end else begin
            sp_o     <= nxt;
            bad_wr_o <= sw_wr && (sw_val <= FLOOR_ADDR);
        end
    end
endmodule

// File: rtl/sp_lock_timer.sv
// Counts retired instructions after a low-byte pointer write and blocks
// interrupts meanwhile; any later I/O write ends the window early.
// Assumes the low-byte write itself is not reported as a later I/O write.
module sp_lock_timer #(
    parameter int LOCK_INSNS = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm_i,
    input  logic io_wr_i,
    input  logic retire_i,
    output logic block_o
);
    localparam int CW = $clog2(LOCK_INSNS + 1);
    localparam logic [CW-1:0] LOAD = CW'(LOCK_INSNS);

    logic [CW-1:0] left_q;

    // Load on arm, clear on I/O write, count down on retire.
    always_ff @(posedge clk) begin
        if (!rst_n)                            left_q <= '0;
        else if (arm_i)                        left_q <= LOAD;
        else if (io_wr_i)                      left_q <= '0;
        else if (retire_i && left_q != '0)     left_q <= left_q - 1'b1;
    end

    // Block while instructions remain in the window.
    always_comb block_o = (left_q != '0);
endmodule

// File: rtl/stack_ptr_unit.sv
// Stack pointer unit: register, per-lane stack addresses, interrupt lockout.
// Assumes one-hot stack requests from the decoder and RET_BYTES of 2 or 3.
module stack_ptr_unit
    import sp_unit_pkg::*;
#(
    parameter int               RET_BYTES  = 2,
    parameter int               LOCK_INSNS = 4,
    parameter logic [15:0]      SRAM_TOP   = 16'h3FFF,
    parameter logic [15:0]      FLOOR_ADDR = 16'h2000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     push_i,
    input  logic                     pop_i,
    input  logic                     call_i,
    input  logic                     ret_i,
    input  logic                     retire_i,
    input  logic                     io_wr_i,
    input  logic                     wr_lo_i,
    input  logic                     wr_hi_i,
    input  logic [7:0]               wr_data_i,
    output logic [15:0]              sp_o,
    output logic [16*RET_BYTES-1:0]  acc_addr_o,
    output logic [RET_BYTES-1:0]     acc_en_o,
    output logic                     acc_wr_o,
    output logic                     irq_block_o,
    output logic                     bad_wr_o
);
    logic [SP_W-1:0] op_next;
    logic            sw_wr;
    logic            io_any;

    // Software write and I/O write summaries.
    always_comb begin
        sw_wr  = wr_lo_i | wr_hi_i;
        io_any = io_wr_i | wr_hi_i;
    end

    sp_op_decode #(.RET_BYTES(RET_BYTES)) u_dec (
        .push_i   (push_i),
        .pop_i    (pop_i),
        .call_i   (call_i),
        .ret_i    (ret_i),
        .sw_wr_i  (sw_wr),
        .sp_i     (sp_o),
        .sp_next_o(op_next),
        .addr_o   (acc_addr_o),
        .en_o     (acc_en_o),
        .wr_o     (acc_wr_o)
    );

    sp_reg #(.SRAM_TOP(SRAM_TOP), .FLOOR_ADDR(FLOOR_ADDR)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_lo_i  (wr_lo_i),
        .wr_hi_i  (wr_hi_i),
        .wr_data_i(wr_data_i),
        .op_next_i(op_next),
        .sp_o     (sp_o),
        .bad_wr_o (bad_wr_o)
    );

    sp_lock_timer #(.LOCK_INSNS(LOCK_INSNS)) u_lock (
        .clk     (clk),
        .rst_n   (rst_n),
        .arm_i   (wr_lo_i),
        .io_wr_i (io_any),
        .retire_i(retire_i),
        .block_o (irq_block_o)
    );
endmodule

// File: rtl/sp_unit_chk.sv
// Checker for the stack pointer unit, attached by bind.
// Assumes it sees the top-level ports only.
module sp_unit_chk #(
    parameter int          RET_BYTES  = 2,
    parameter int          LOCK_INSNS = 4,
    parameter logic [15:0] SRAM_TOP   = 16'h3FFF,
    parameter logic [15:0] FLOOR_ADDR = 16'h2000
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    push_i,
    input logic                    pop_i,
    input logic                    call_i,
    input logic                    ret_i,
    input logic                    retire_i,
    input logic                    io_wr_i,
    input logic                    wr_lo_i,
    input logic                    wr_hi_i,
    input logic [7:0]              wr_data_i,
    input logic [15:0]             sp_o,
    input logic [16*RET_BYTES-1:0] acc_addr_o,
    input logic [RET_BYTES-1:0]    acc_en_o,
    input logic                    acc_wr_o,
    input logic                    irq_block_o,
    input logic                    bad_wr_o
);
    localparam int CW = $clog2(LOCK_INSNS + 1);
    localparam logic [15:0] STEP_RA = 16'(RET_BYTES);

    logic sw, quiet;
    logic [CW-1:0] seen_q;

    always_comb begin
        sw    = wr_lo_i | wr_hi_i;
        quiet = !sw && !(push_i | pop_i | call_i | ret_i);
    end

    // Retire pulses seen inside the current lockout window.
    always_ff @(posedge clk) begin
        if (!rst_n || wr_lo_i)                                     seen_q <= '0;
        else if (retire_i && irq_block_o && seen_q != CW'(LOCK_INSNS)) seen_q <= seen_q + 1'b1;
    end

    AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({push_i, pop_i, call_i, ret_i}) <= 1); // R10
    AST_RESET_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sp_o == SRAM_TOP && !irq_block_o && !bad_wr_o)); // R1
    AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !sw) |=> sp_o == $past(sp_o) - 16'd1); // R2
    AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !sw) |=> sp_o == $past(sp_o) + 16'd1); // R3
    AST_CALL_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !sw) |=> sp_o == $past(sp_o) - STEP_RA); // R4
    AST_RET_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !sw) |=> sp_o == $past(sp_o) + STEP_RA); // R5
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw |-> acc_en_o == '0); // R6
    AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
        wr_lo_i |=> irq_block_o); // R7
    AST_LOCK_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        irq_block_o |-> seen_q < CW'(LOCK_INSNS)); // R7
    AST_LOCK_IO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((io_wr_i || wr_hi_i) && !wr_lo_i) |=> !irq_block_o); // R8
    AST_FLOOR_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        bad_wr_o |-> (sp_o <= FLOOR_ADDR && $past(sw))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |=> $stable(sp_o)); // R10
    AST_IDLE_NO_LANE: assert property (@(posedge clk) disable iff (!rst_n)
        quiet |-> (acc_en_o == '0 && !acc_wr_o)); // R10

    // Keep every observed input referenced.
    logic unused_ok;
    always_comb unused_ok = ^{wr_data_i, acc_addr_o};
endmodule

bind stack_ptr_unit sp_unit_chk #(
    .RET_BYTES(RET_BYTES), .LOCK_INSNS(LOCK_INSNS),
    .SRAM_TOP(SRAM_TOP), .FLOOR_ADDR(FLOOR_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
    .call_i(call_i), .ret_i(ret_i), .retire_i(retire_i), .io_wr_i(io_wr_i),
    .wr_lo_i(wr_lo_i), .wr_hi_i(wr_hi_i), .wr_data_i(wr_data_i),
    .sp_o(sp_o), .acc_addr_o(acc_addr_o), .acc_en_o(acc_en_o),
    .acc_wr_o(acc_wr_o), .irq_block_o(irq_block_o), .bad_wr_o(bad_wr_o)
);

// File: tb/sim_stack_ptr_unit.sv
module sim_stack_ptr_unit;
    localparam int          RB    = 2;
    localparam int          LOCK  = 4;
    localparam logic [15:0] TOP   = 16'h3FFF;
    localparam logic [15:0] FLOOR = 16'h2000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic push, pop, call, ret, retire, iow, wlo, whi;
    logic [7:0] wdat;
    logic [15:0] sp;
    logic [16*RB-1:0] addr;
    logic [RB-1:0] en;
    logic wr, blk, bad;

    int n_chk = 0, n_bad = 0;
    logic [15:0] m_sp;
    int m_left;
    logic m_bad;

    always #10 clk = ~clk;

    stack_ptr_unit #(.RET_BYTES(RB), .LOCK_INSNS(LOCK), .SRAM_TOP(TOP),
                     .FLOOR_ADDR(FLOOR)) u0 (
        .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .call_i(call),
        .ret_i(ret), .retire_i(retire), .io_wr_i(iow), .wr_lo_i(wlo),
        .wr_hi_i(whi), .wr_data_i(wdat), .sp_o(sp), .acc_addr_o(addr),
        .acc_en_o(en), .acc_wr_o(wr), .irq_block_o(blk), .bad_wr_o(bad));

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic string op_req();
        if (wlo || whi) return "R6";
        if (call) return "R4";
        if (ret)  return "R5";
        if (push) return "R2";
        if (pop)  return "R3";
        return "R10";
    endfunction

    // Expected lane address for lane b under the current inputs.
    function automatic logic [15:0] exp_addr(int b);
        if (call) return m_sp - 16'(b);
        if (ret)  return m_sp + 16'(RB - b);
        if (push) return m_sp;
        return m_sp + 16'd1;
    endfunction

    function automatic logic [RB-1:0] exp_en();
        if (wlo || whi) return '0;
        if (call || ret) return '1;
        if (push || pop) return RB'(1);
        return '0;
    endfunction

    // Apply one cycle of stimulus (called at a negative edge) and check.
    task automatic step(input logic p, po, c, r, rt, io, lo, hi,
                        input logic [7:0] d);
        string rq;
        logic [15:0] sw_val;
        push = p; pop = po; call = c; ret = r; retire = rt;
        iow = io; wlo = lo; whi = hi; wdat = d;
        #1;
        rq = op_req();
        chk(en == exp_en(), rq, 32'(en), 32'(exp_en()));
        if (exp_en() != '0)
            chk(wr == (push || call), rq, 32'(wr), 32'(push || call));
        for (int b = 0; b < RB; b++)
            if (exp_en()[b])
                chk(addr[b*16 +: 16] == exp_addr(b), rq,
                    32'(addr[b*16 +: 16]), 32'(exp_addr(b)));
        @(posedge clk);
        sw_val = {hi ? d : m_sp[15:8], lo ? d : m_sp[7:0]};
        m_bad = (lo || hi) && (sw_val <= FLOOR);
        if (lo || hi)    m_sp = sw_val;
        else if (c)      m_sp = m_sp - 16'(RB);
        else if (r)      m_sp = m_sp + 16'(RB);
        else if (p)      m_sp = m_sp - 16'd1;
        else if (po)     m_sp = m_sp + 16'd1;
        if (lo)                  m_left = LOCK;
        else if (io || hi)       m_left = 0;
        else if (rt && m_left > 0) m_left--;
        @(negedge clk);
        chk(sp == m_sp, rq, 32'(sp), 32'(m_sp));
        chk(blk == (m_left != 0), (lo || io || hi) ? "R8" : "R7",
            32'(blk), 32'(m_left != 0));
        chk(bad == m_bad, "R9", 32'(bad), 32'(m_bad));
    endtask

    task automatic idle(input logic rt);
        step(0, 0, 0, 0, rt, 0, 0, 0, 8'h00);
    endtask

    bit done = 0;

    initial begin
        {push, pop, call, ret, retire, iow, wlo, whi} = '0;
        wdat = 8'h00;
        m_sp = TOP; m_left = 0; m_bad = 1'b0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(sp == TOP, "R1", 32'(sp), 32'(TOP));
        chk(!blk && !bad, "R1", 32'({blk, bad}), 0);
        chk(en == '0, "R1", 32'(en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(sp == TOP, "R1", 32'(sp), 32'(TOP));

        // Directed: push, pop, call, return (R2..R5)
        step(1, 0, 0, 0, 0, 0, 0, 0, 8'h00);
        step(0, 1, 0, 0, 0, 0, 0, 0, 8'h00);
        step(0, 0, 1, 0, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 0, 0, 0, 8'h00);
        idle(0); // R10

        // R7: low write, retire same cycle not counted, then four retires
        step(0, 0, 0, 0, 1, 0, 1, 0, 8'h80);
        for (int i = 0; i < LOCK + 1; i++) idle(1);
        // R8: low write then I/O write ends the window
        step(0, 0, 0, 0, 0, 0, 1, 0, 8'h40);
        idle(1);
        step(0, 0, 0, 0, 0, 1, 0, 0, 8'h00);
        // R8 via high-byte write; R6 write beats a push
        step(1, 0, 0, 0, 0, 0, 1, 0, 8'h00);
        step(0, 0, 1, 0, 0, 0, 0, 1, 8'h30);
        // R9: exactly at floor, one above floor
        step(0, 0, 0, 0, 0, 0, 1, 1, 8'h20);
        step(0, 0, 0, 0, 0, 0, 1, 0, 8'h00);
        step(0, 0, 0, 0, 0, 0, 1, 0, 8'h01);
        idle(0);
        // R10: wrap below zero and back
        step(0, 0, 0, 0, 0, 0, 1, 1, 8'h00);
        step(0, 0, 1, 0, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 1, 0, 0, 0, 0, 8'h00);
        step(0, 0, 0, 0, 0, 0, 1, 1, 8'h31);

        // Random mix, one request code per cycle
        void'($urandom(32'd1234));
        for (int i = 0; i < 3000; i++) begin
            int code, wsel;
            code = $urandom_range(0, 5);
            wsel = $urandom_range(0, 19);
            step(code == 1, code == 2, code == 3, code == 4,
                 $urandom_range(0, 1) == 1, $urandom_range(0, 9) == 0,
                 wsel == 0 || wsel == 2, wsel == 1 || wsel == 2,
                 8'($urandom_range(0, 255)));
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule